// File: doc/BRIEF.md
# Cached-Payload Transmit Packet Assembler

This block sits on the transmit side of a network interface. It keeps a local payload store that the host fills over a host-memory read port. It then builds outgoing packets from header bytes the host supplies and from payload segments. Each segment is taken either from the local store, by offset and length, or from host memory. The host writes descriptors one at a time on a valid/ready port. A fill descriptor copies a host range into the store. A transmit descriptor opens a packet and announces how many header bytes follow on the header stream. Segment descriptors then list the payload pieces in order, and the final descriptor of a packet carries a last flag.

The whole packet is first collected in an internal packet buffer. While the bytes are collected, the block sums them into a 16-bit ones'-complement checksum over a programmable span. It then drives the packet out on a byte-wide valid/ready stream, with the inverted checksum placed at a programmable header position. Descriptors are executed strictly one after another, so a transmit always sees the data of every earlier fill. A command that does not fit the store or the packet buffer raises a one-cycle error pulse, and no frame is sent for it.

Top module: `txpkt_asm`

## Requirements
- R1: A descriptor with op code 0 (fill) reads `len` bytes from host addresses `addr` to `addr+len-1` in ascending order, one byte per host request. It writes them to the local store starting at store offset `off`.
- R2: A descriptor with op code 1 (transmit) opens a packet. Its `len` bytes are taken from the header stream and form the first bytes of the frame. `off` is the checksum field position and `addr` is the checksum span start, both counted from the first header byte. With its last flag set, the frame holds the headers only.
- R3: Segment descriptors follow a transmit descriptor. Op code 2 takes `len` bytes from the local store at `off`. Op code 3 fetches `len` bytes from host memory at `addr` over the host port. The frame is the headers followed by the segments in the order listed, and the descriptor with the last flag closes the packet.
- R4: A store segment may start partway into a store block and may run across several consecutive blocks of `BLK_BYTES` bytes. Its bytes come out unchanged.
- R5: The checksum is the 16-bit ones'-complement sum, with end-around carry, of all frame bytes from the span start to the end of the frame. The first byte of the span is a high-order byte, the bytes then alternate, and an odd final byte is padded with a zero low-order byte. The inverted sum replaces frame bytes `off` (high byte) and `off+1` (low byte). The host supplies zeros in those two bytes.
- R6: The output stream raises `out_last_o` on the final byte only. While `out_valid_o` is high and `out_ready_i` is low, data and last stay unchanged.
- R7: While a frame is draining, no descriptor and no header byte is accepted.
- R8: A fill whose `off+len` exceeds the store size raises `err_o` for one cycle and leaves the store unchanged.
- R9: A packet is rejected in any of these cases, raising `err_o` for one cycle and emitting no frame: a store segment with `off+len` beyond the store, a total length above `PKT_MAX`, an empty packet, or a non-segment op code inside the segment list. Its remaining descriptors up to the last flag are still consumed.
- R10: Descriptors execute in arrival order, so a transmit that follows a fill reads the newly written store bytes.
- R11: A host request holds `hreq_valid_o` and `hreq_addr_o` until `hreq_ready_i`. Responses return one byte each, in request order.
- R12: After reset, `out_valid_o`, `hreq_valid_o` and `err_o` are low and `desc_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor valid |
| desc_ready_o | output | 1 | Descriptor accepted |
| desc_op_i | input | 2 | 0 fill, 1 transmit, 2 store segment, 3 host segment |
| desc_last_i | input | 1 | Closes the current packet |
| desc_addr_i | input | HADDR_W | Host address, or checksum span start for op 1 |
| desc_off_i | input | LEN_W | Store offset, or checksum field position for op 1 |
| desc_len_i | input | LEN_W | Byte count, or header length for op 1 |
| hdr_valid_i | input | 1 | Header byte valid |
| hdr_ready_o | output | 1 | Header byte accepted |
| hdr_data_i | input | 8 | Header byte |
| hreq_valid_o | output | 1 | Host read request valid |
| hreq_ready_i | input | 1 | Host read request accepted |
| hreq_addr_o | output | HADDR_W | Host byte address |
| hrsp_valid_i | input | 1 | Host read response valid |
| hrsp_data_i | input | 8 | Host read response byte |
| out_valid_o | output | 1 | Frame byte valid |
| out_ready_i | input | 1 | Frame byte accepted |
| out_data_o | output | 8 | Frame byte |
| out_last_o | output | 1 | Final byte of frame |
| err_o | output | 1 | One-cycle rejection pulse |

## Verification
The assertions check the handshake rules on every cycle. Output data and last must hold under backpressure, and the host address must hold while a request waits and step by one between accepted requests. No descriptor or header byte may be taken while a frame drains, and an error pulse never coincides with frame output. Only the bench scenarios can show that the bytes are correct. These scenarios cover segments crossing block edges, mixed store and host segments in order, checksum values for odd and even spans, and a fill followed at once by a transmit. They also show that rejected fills leave the store untouched and that rejected packets produce no frame while later packets still go out.

// File: rtl/txa_pkg.sv
package txa_pkg;
  typedef enum logic [1:0] {
    OP_FILL     = 2'd0,
    OP_TX       = 2'd1,
    OP_SEG_ST   = 2'd2,
    OP_SEG_HOST = 2'd3
  } txa_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_HDR,
    S_NEXT,
    S_STORE,
    S_HOST,
    S_END,
    S_SEND
  } txa_state_e;
endpackage

// File: rtl/txa_store.sv
module txa_store #(
  parameter int BYTES = 2048,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [BYTES];
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/txa_pkt_buf.sv
module txa_pkt_buf #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // buffer is frozen while a frame drains, so a direct read keeps data stable
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txa_csum.sv
module txa_csum (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] csum_o
);
  logic [15:0] acc_q;
  logic        hi_q;
  logic [16:0] sum;

  assign sum = {1'b0, acc_q} + (hi_q ? {1'b0, data_i, 8'h00} : {9'h000, data_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      hi_q  <= 1'b1;
    end else if (clr_i) begin
      acc_q <= '0;
      hi_q  <= 1'b1;
    end else if (en_i) begin
      acc_q <= sum[15:0] + {15'h0000, sum[16]};
      hi_q  <= !hi_q;
    end
  end

  assign csum_o = ~acc_q;
endmodule

// File: rtl/txpkt_asm.sv
module txpkt_asm
  import txa_pkg::*;
#(
  parameter int HADDR_W   = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_BYTES = 256,
  parameter int NUM_BLKS  = 8,
  parameter int PKT_MAX   = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_valid_i,
  output logic               desc_ready_o,
  input  logic [1:0]         desc_op_i,
  input  logic               desc_last_i,
  input  logic [HADDR_W-1:0] desc_addr_i,
  input  logic [LEN_W-1:0]   desc_off_i,
  input  logic [LEN_W-1:0]   desc_len_i,
  input  logic               hdr_valid_i,
  output logic               hdr_ready_o,
  input  logic [7:0]         hdr_data_i,
  output logic               hreq_valid_o,
  input  logic               hreq_ready_i,
  output logic [HADDR_W-1:0] hreq_addr_o,
  input  logic               hrsp_valid_i,
  input  logic [7:0]         hrsp_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [7:0]         out_data_o,
  output logic               out_last_o,
  output logic               err_o
);
  localparam int STORE_BYTES = BLK_BYTES * NUM_BLKS;
  localparam int STORE_AW    = $clog2(STORE_BYTES);
  localparam int PKT_AW      = $clog2(PKT_MAX);
  localparam int CW          = LEN_W + 1;
  localparam logic [CW-1:0]    STORE_LIM = CW'(STORE_BYTES);
  localparam logic [CW-1:0]    PKT_LIM   = CW'(PKT_MAX);
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

  txa_state_e         state_q;
  txa_op_e            d_op;
  logic               cur_last_q, tx_bad_q, err_q, pipe_v_q;
  logic [LEN_W-1:0]   pkt_len_q, span_q, cpos_q, hdr_left_q;
  logic [LEN_W-1:0]   req_left_q, rsp_left_q, rd_left_q, rd_idx_q, ptr_q;
  logic [HADDR_W-1:0] req_addr_q;
  logic               desc_fire, hdr_fire, hreq_fire, out_fire, rsp_take;
  logic               store_oob, pkt_oob, seg_skip, is_seg;
  logic               bw_en, st_re, st_we, cs_clr;
  logic [7:0]         bw_data, st_rdata, pb_rdata;
  logic [15:0]        csum;
  txa_state_e         after_seg;

  assign d_op = txa_op_e'(desc_op_i);

  assign desc_ready_o = (state_q == S_IDLE) || (state_q == S_NEXT);
  assign hdr_ready_o  = (state_q == S_HDR);
  assign hreq_valid_o = ((state_q == S_FILL) || (state_q == S_HOST)) && (req_left_q != '0);
  assign hreq_addr_o  = req_addr_q;
  assign out_valid_o  = (state_q == S_SEND);
  assign err_o        = err_q;

  assign desc_fire = desc_valid_i && desc_ready_o;
  assign hdr_fire  = hdr_valid_i && hdr_ready_o;
  assign hreq_fire = hreq_valid_o && hreq_ready_i;
  assign out_fire  = out_valid_o && out_ready_i;
  assign rsp_take  = hrsp_valid_i && (rsp_left_q != '0) &&
                     ((state_q == S_FILL) || (state_q == S_HOST));

  assign store_oob = ({1'b0, desc_off_i} + {1'b0, desc_len_i}) > STORE_LIM;
  assign pkt_oob   = ({1'b0, pkt_len_q} + {1'b0, desc_len_i}) > PKT_LIM;
  assign seg_skip  = tx_bad_q || (desc_len_i == '0);
  assign is_seg    = (d_op == OP_SEG_ST) || (d_op == OP_SEG_HOST);
  assign after_seg = cur_last_q ? S_END : S_NEXT;

  // single write point into the packet buffer
  always_comb begin
    bw_en   = 1'b0;
    bw_data = hdr_data_i;
    unique case (state_q)
      S_HDR:   bw_en = hdr_fire && !tx_bad_q;
      S_STORE: begin bw_en = pipe_v_q; bw_data = st_rdata; end
      S_HOST:  begin bw_en = rsp_take; bw_data = hrsp_data_i; end
      default: ;
    endcase
  end

  assign st_re  = (state_q == S_STORE) && (rd_left_q != '0);
  assign st_we  = (state_q == S_FILL) && rsp_take;
  assign cs_clr = (state_q == S_IDLE) && desc_fire && (d_op == OP_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cur_last_q <= 1'b0;
      tx_bad_q   <= 1'b0;
      err_q      <= 1'b0;
      pipe_v_q   <= 1'b0;
      pkt_len_q  <= '0;
      span_q     <= '0;
      cpos_q     <= '0;
      hdr_left_q <= '0;
      req_left_q <= '0;
      rsp_left_q <= '0;
      rd_left_q  <= '0;
      rd_idx_q   <= '0;
      ptr_q      <= '0;
      req_addr_q <= '0;
    end else begin
      err_q    <= 1'b0;
      pipe_v_q <= st_re;
      if (bw_en) pkt_len_q <= pkt_len_q + ONE;
      if (hreq_fire) begin
        req_addr_q <= req_addr_q + HADDR_W'(1);
        req_left_q <= req_left_q - ONE;
      end
      if (rsp_take) rsp_left_q <= rsp_left_q - ONE;
      if (st_we) ptr_q <= ptr_q + ONE;
      if (st_re) begin
        ptr_q     <= ptr_q + ONE;
        rd_left_q <= rd_left_q - ONE;
      end

      unique case (state_q)
        S_IDLE: if (desc_fire) begin
          case (d_op)
            OP_FILL: begin
              if (store_oob) err_q <= 1'b1;
              else if (desc_len_i != '0) begin
                ptr_q      <= desc_off_i;
                req_addr_q <= desc_addr_i;
                req_left_q <= desc_len_i;
                rsp_left_q <= desc_len_i;
                state_q    <= S_FILL;
              end
            end
            OP_TX: begin
              pkt_len_q  <= '0;
              tx_bad_q   <= {1'b0, desc_len_i} > PKT_LIM;
              span_q     <= desc_addr_i[LEN_W-1:0];
              cpos_q     <= desc_off_i;
              hdr_left_q <= desc_len_i;
              cur_last_q <= desc_last_i;
              if (desc_len_i != '0) state_q <= S_HDR;
              else                  state_q <= desc_last_i ? S_END : S_NEXT;
            end
            default: err_q <= 1'b1;  // segment with no open packet
          endcase
        end
        S_HDR: if (hdr_fire) begin
          hdr_left_q <= hdr_left_q - ONE;
          if (hdr_left_q == ONE) state_q <= after_seg;
        end
        S_NEXT: if (desc_fire) begin
          cur_last_q <= desc_last_i;
          state_q    <= desc_last_i ? S_END : S_NEXT;
          if (!is_seg) tx_bad_q <= 1'b1;
          else if (!seg_skip) begin
            if (pkt_oob || ((d_op == OP_SEG_ST) && store_oob)) tx_bad_q <= 1'b1;
            else if (d_op == OP_SEG_ST) begin
              ptr_q     <= desc_off_i;
              rd_left_q <= desc_len_i;
              state_q   <= S_STORE;
            end else begin
              req_addr_q <= desc_addr_i;
              req_left_q <= desc_len_i;
              rsp_left_q <= desc_len_i;
              state_q    <= S_HOST;
            end
          end
        end
        S_STORE: if ((rd_left_q == '0) && !pipe_v_q) state_q <= after_seg;
        S_FILL:  if (rsp_left_q == '0) state_q <= S_IDLE;
        S_HOST:  if (rsp_left_q == '0) state_q <= after_seg;
        S_END: begin
          if (tx_bad_q || (pkt_len_q == '0)) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            rd_idx_q <= '0;
            state_q  <= S_SEND;
          end
        end
        S_SEND: if (out_fire) begin
          if (out_last_o) state_q <= S_IDLE;
          else            rd_idx_q <= rd_idx_q + ONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  txa_store #(.BYTES(STORE_BYTES)) u_store (
    .clk_i   (clk_i),
    .we_i    (st_we),
    .waddr_i (ptr_q[STORE_AW-1:0]),
    .wdata_i (hrsp_data_i),
    .re_i    (st_re),
    .raddr_i (ptr_q[STORE_AW-1:0]),
    .rdata_o (st_rdata)
  );

  txa_pkt_buf #(.DEPTH(PKT_MAX)) u_pkt_buf (
    .clk_i   (clk_i),
    .we_i    (bw_en),
    .waddr_i (pkt_len_q[PKT_AW-1:0]),
    .wdata_i (bw_data),
    .raddr_i (rd_idx_q[PKT_AW-1:0]),
    .rdata_o (pb_rdata)
  );

  txa_csum u_csum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_clr),
    .en_i   (bw_en && (pkt_len_q >= span_q)),
    .data_i (bw_data),
    .csum_o (csum)
  );

  assign out_last_o = out_valid_o && (rd_idx_q == pkt_len_q - ONE);

  always_comb begin
    if (rd_idx_q == cpos_q)            out_data_o = csum[15:8];
    else if (rd_idx_q == cpos_q + ONE) out_data_o = csum[7:0];
    else                               out_data_o = pb_rdata;
  end
endmodule

// File: rtl/txpkt_asm_chk.sv
module txpkt_asm_chk #(
  parameter int HADDR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               desc_ready_o,
  input logic               hdr_ready_o,
  input logic               hreq_valid_o,
  input logic               hreq_ready_i,
  input logic [HADDR_W-1:0] hreq_addr_o,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [7:0]         out_data_o,
  input logic               out_last_o,
  input logic               err_o
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o)); // R6

  AST_LAST_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R6

  AST_NO_ACCEPT_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !desc_ready_o && !hdr_ready_o); // R7

  AST_HREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_o && !hreq_ready_i |=> hreq_valid_o && $stable(hreq_addr_o)); // R11

  AST_HREQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_valid_o && hreq_ready_i |=> !hreq_valid_o || (hreq_addr_o == $past(hreq_addr_o) + HADDR_W'(1))); // R1

  AST_ERR_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !out_valid_o); // R9

  AST_HOST_IDLE_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !hreq_valid_o); // R7
endmodule

bind txpkt_asm txpkt_asm_chk #(.HADDR_W(HADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .desc_ready_o (desc_ready_o),
  .hdr_ready_o  (hdr_ready_o),
  .hreq_valid_o (hreq_valid_o),
  .hreq_ready_i (hreq_ready_i),
  .hreq_addr_o  (hreq_addr_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_data_o   (out_data_o),
  .out_last_o   (out_last_o),
  .err_o        (err_o)
);

// File: tb/txpkt_asm_tb_top.sv
module txpkt_asm_tb_top;
  localparam int SB = 2048;  // store bytes: 256 x 8
  localparam int PM = 512;

  typedef struct {
    logic [1:0]  op;
    logic        last;
    logic [31:0] addr;
    logic [15:0] off;
    logic [15:0] len;
  } d_t;
  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } e_t;

  logic clk = 1'b0;
  logic rst_n;
  logic desc_valid, desc_ready, desc_last, hdr_valid, hdr_ready;
  logic [1:0] desc_op;
  logic [31:0] desc_addr;
  logic [15:0] desc_off, desc_len;
  logic [7:0] hdr_data, hrsp_data, out_data;
  logic hreq_valid, hreq_ready, hrsp_valid, out_valid, out_ready, out_last, err;
  logic [31:0] hreq_addr;

  always #2 clk = ~clk;  // 250 MHz

  txpkt_asm #(.HADDR_W(32), .LEN_W(16), .BLK_BYTES(256), .NUM_BLKS(8), .PKT_MAX(PM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_valid_i(desc_valid), .desc_ready_o(desc_ready), .desc_op_i(desc_op),
    .desc_last_i(desc_last), .desc_addr_i(desc_addr), .desc_off_i(desc_off), .desc_len_i(desc_len),
    .hdr_valid_i(hdr_valid), .hdr_ready_o(hdr_ready), .hdr_data_i(hdr_data),
    .hreq_valid_o(hreq_valid), .hreq_ready_i(hreq_ready), .hreq_addr_o(hreq_addr),
    .hrsp_valid_i(hrsp_valid), .hrsp_data_i(hrsp_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .err_o(err)
  );

  int checks = 0, failures = 0, err_seen = 0, err_exp = 0;
  d_t desc_q[$];
  logic [7:0] hdr_q[$], rsp_q[$], pkt_q[$];
  e_t exp_q[$];
  logic [7:0] store_m [SB];
  int span, cpos;
  bit prev_hold = 0, prev_hq = 0;
  logic [7:0] prev_d;
  logic prev_l;
  logic [31:0] prev_a;

  function automatic logic [7:0] hmem(int a);
    return 8'((a * 3) ^ (a >> 7) ^ 8'h5A);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_d(logic [1:0] op, logic last, int addr, int off, int len);
    d_t d;
    d.op = op; d.last = last; d.addr = addr; d.off = 16'(off); d.len = 16'(len);
    desc_q.push_back(d);
  endtask

  task automatic fill(int addr, int off, int len);
    push_d(2'd0, 1'b0, addr, off, len);
    if (off + len <= SB) for (int i = 0; i < len; i++) store_m[off+i] = hmem(addr + i);
  endtask

  task automatic tx_begin(int hlen, int start, int pos, bit last);
    push_d(2'd1, last, start, pos, hlen);
    pkt_q.delete();
    span = start; cpos = pos;
    for (int i = 0; i < hlen; i++) begin
      logic [7:0] b;
      b = (i == pos || i == pos + 1) ? 8'h00 : 8'(8'hA0 + i);
      hdr_q.push_back(b);
      pkt_q.push_back(b);
    end
  endtask

  task automatic seg_store(int off, int len, bit last);
    push_d(2'd2, last, 0, off, len);
    for (int i = 0; i < len; i++) pkt_q.push_back((off + i < SB) ? store_m[off+i] : 8'h00);
  endtask

  task automatic seg_host(int addr, int len, bit last);
    push_d(2'd3, last, addr, 0, len);
    for (int i = 0; i < len; i++) pkt_q.push_back(hmem(addr + i));
  endtask

  task automatic tx_commit(string tag);
    int s = 0;
    logic [15:0] c;
    for (int i = span; i < pkt_q.size(); i++)
      s += ((i - span) % 2 == 0) ? (int'(pkt_q[i]) << 8) : int'(pkt_q[i]);
    while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >>> 16);
    c = ~16'(s);
    if (cpos < pkt_q.size()) pkt_q[cpos] = c[15:8];
    if (cpos + 1 < pkt_q.size()) pkt_q[cpos+1] = c[7:0];
    for (int i = 0; i < pkt_q.size(); i++) begin
      e_t e;
      e.d = pkt_q[i]; e.l = (i == pkt_q.size() - 1); e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle(string tag);
    while (desc_q.size() != 0 || hdr_q.size() != 0 || exp_q.size() != 0 ||
           rsp_q.size() != 0 || hreq_valid) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(err_seen == err_exp, tag, "error pulse count", err_seen, err_exp);
  endtask

  // driver and monitor: inputs change at the falling edge, handshakes are judged 1 ns later
  always @(negedge clk) begin
    if (rst_n) begin
      desc_valid = desc_q.size() != 0;
      if (desc_valid) begin
        desc_op = desc_q[0].op; desc_last = desc_q[0].last; desc_addr = desc_q[0].addr;
        desc_off = desc_q[0].off; desc_len = desc_q[0].len;
      end
      hdr_valid = hdr_q.size() != 0;
      if (hdr_valid) hdr_data = hdr_q[0];
      hreq_ready = $urandom_range(0, 3) != 0;
      out_ready  = $urandom_range(0, 3) != 0;
      if (rsp_q.size() != 0) begin
        hrsp_valid = 1'b1;
        hrsp_data  = rsp_q.pop_front();
      end else hrsp_valid = 1'b0;
      #1;
      if (err) err_seen++;
      if (prev_hold)
        chk(out_valid && out_data == prev_d && out_last == prev_l, "R6", "held byte",
            int'(out_data), int'(prev_d));
      if (prev_hq)
        chk(hreq_valid && hreq_addr == prev_a, "R11", "held request addr",
            int'(hreq_addr), int'(prev_a));
      if (out_valid)
        chk(!desc_ready && !hdr_ready, "R7", "accept while draining",
            int'({desc_ready, hdr_ready}), 0);
      if (desc_valid && desc_ready) void'(desc_q.pop_front());
      if (hdr_valid && hdr_ready) void'(hdr_q.pop_front());
      if (hreq_valid && hreq_ready) rsp_q.push_back(hmem(int'(hreq_addr)));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R9", "unexpected frame byte", int'(out_data), 0);
        else begin
          e_t e;
          e = exp_q.pop_front();
          chk(out_data == e.d, e.tag, "frame byte", int'(out_data), int'(e.d));
          chk(out_last == e.l, "R6", "last flag", int'(out_last), int'(e.l));
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_d = out_data; prev_l = out_last;
      prev_hq = hreq_valid && !hreq_ready;
      prev_a = hreq_addr;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    desc_valid = 0; desc_op = 0; desc_last = 0; desc_addr = 0; desc_off = 0; desc_len = 0;
    hdr_valid = 0; hdr_data = 0; hreq_ready = 0; hrsp_valid = 0; hrsp_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R12", "out_valid in reset", int'(out_valid), 0);
    chk(!hreq_valid, "R12", "hreq_valid in reset", int'(hreq_valid), 0);
    chk(!err, "R12", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(desc_ready, "R12", "desc_ready after reset", int'(desc_ready), 1);

    // R1: fills spanning several blocks, the second ending exactly at the store top
    fill(32'h100, 0, 600);
    fill(32'h1000, 1800, 248);
    // R4: store segment starting mid block and crossing a block edge
    tx_begin(20, 12, 16, 1'b0);
    seg_store(200, 100, 1'b1);
    tx_commit("R1/R4");
    wait_idle("R1");

    // R3 R5: mixed segments in order, odd total length; next packet queued while draining (R7)
    tx_begin(8, 0, 2, 1'b0);
    seg_store(10, 40, 1'b0);
    seg_host(32'h800, 33, 1'b0);
    seg_store(1990, 58, 1'b1);
    tx_commit("R3/R5");
    // R10: fill then immediate transmit of the rewritten range
    fill(32'h2000, 220, 50);
    tx_begin(4, 0, 0, 1'b0);
    seg_store(210, 80, 1'b1);
    tx_commit("R10");
    wait_idle("R10");

    // R8: fill past the store top is rejected, store keeps old bytes
    fill(0, 2040, 16);
    err_exp++;
    tx_begin(6, 2, 4, 1'b0);
    seg_store(2030, 18, 1'b1);
    tx_commit("R8");
    wait_idle("R8");

    // R9: out-of-range store segment, then an oversize packet; neither emits a frame
    tx_begin(10, 0, 0, 1'b0);
    seg_store(2000, 100, 1'b0);
    seg_host(32'h10, 5, 1'b1);
    err_exp++;
    tx_begin(100, 0, 0, 1'b0);
    seg_host(0, 300, 1'b0);
    seg_store(0, 200, 1'b1);
    err_exp++;
    wait_idle("R9");

    // R2: headers only
    tx_begin(16, 0, 6, 1'b1);
    tx_commit("R2");
    // R9 boundary: exactly PKT_MAX bytes is accepted
    tx_begin(12, 0, 10, 1'b0);
    seg_store(0, PM - 12, 1'b1);
    tx_commit("R9");
    wait_idle("R2");

    finish_run();
  end
endmodule